// File: doc/BRIEF.md
# Receive Byte Mover with Buffer Drain

This block takes serial receive bytes and places them in memory. Bytes that arrive while no transfer is pending are held in a small receive queue. Software can pop them one at a time, or hand them to memory. Software starts a transfer by writing a byte count. The block first empties up to that many bytes from the queue, one byte per granted cycle, into memory at consecutive addresses. Any part of the count that the queue could not cover is kept as an outstanding length. While that length is nonzero, each newly arriving byte skips the queue and is written straight to the next memory address.

Writing the pointer register loads a new memory address and drops any outstanding length. If a drain is in progress, it stops, and the bytes not yet moved stay in the queue. The block shows its pointer, its outstanding length, a transfer-complete flag for the interrupt logic, and a receive credit. The credit tells the serial front end how many bytes it may still send.

Top module: `rx_dma_drain`

## Requirements
- R1: After reset, the pointer is 0, the outstanding length is 0, the complete flag is 1, the queue is empty, the credit equals the queue depth, `in_ready` is 1 and `mem_req` is 0.
- R2: A count write of N while idle, with the queue holding at least N bytes, moves exactly N bytes to memory and leaves the outstanding length at 0.
- R3: A count write of N while idle, with the queue holding L < N bytes, moves all L bytes and sets the outstanding length to N - L in the cycle after the write.
- R4: Drained bytes go to memory in arrival order at consecutive addresses, starting at the pointer. The pointer ends one past the last byte written.
- R5: While the outstanding length is nonzero, an accepted input byte is written to memory at the pointer. The pointer then rises by 1 and the length falls by 1, and the queue level is unchanged.
- R6: A pointer write loads the pointer and sets the outstanding length to 0 in the next cycle. It also stops a drain in progress, leaving the bytes not yet moved in the queue, and no further memory writes follow.
- R7: The credit equals the outstanding length when that is nonzero. Otherwise it equals the queue depth minus the queue level.
- R8: The complete flag is 1 exactly when the outstanding length is 0.
- R9: A drain moves one byte on each cycle that `mem_grant` is 1, and holds `mem_req` and `mem_addr` steady while it waits. `in_ready` is 0 while a drain is in progress, and count writes made during a drain are ignored.
- R10: A count write of 0 leaves the outstanding length at 0 and causes no memory write.
- R11: A software pop shows the oldest queued byte on `sw_pop_data` and removes it. On an empty queue, `sw_pop_data` reads 0xFF and the pop has no effect.
- R12: With the outstanding length at 0 and the queue full, `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr_we | input | 1 | Pointer register write strobe |
| cfg_addr_wdata | input | AW | New pointer value |
| cfg_len_we | input | 1 | Count register write strobe (starts a transfer) |
| cfg_len_wdata | input | LW | Requested byte count |
| rx_addr | output | AW | Current memory pointer |
| rx_remain | output | LW | Outstanding length |
| rx_done | output | 1 | Transfer complete (outstanding length is 0) |
| rx_credit | output | LW | Bytes the front end may still deliver |
| in_valid | input | 1 | Input byte valid |
| in_data | input | DW | Input byte |
| in_ready | output | 1 | Input byte accepted when high together with in_valid |
| sw_pop | input | 1 | Software pop of the queue |
| sw_pop_data | output | DW | Oldest queued byte, all ones when empty |
| fifo_level | output | LVL_W | Queue fill level |
| mem_req | output | 1 | Memory byte write request |
| mem_addr | output | AW | Memory write address |
| mem_data | output | DW | Memory write byte |
| mem_grant | input | 1 | Memory accepts the request this cycle |

## Verification
The bench builds the block with its defaults: an 8-entry queue of 8-bit bytes and 16-bit pointer and count. With only 8 entries, a full queue, a full 8-byte drain and the credit dropping to zero are all reached in a few dozen cycles. The bench also runs the drain under three grant patterns: always granted, granted three cycles in four, and never granted. The last pattern holds a drain open long enough to show that a pointer write cancels it partway and that a count write made during it is ignored.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_DRAIN = 1'b1
  } rxd_state_e;
endpackage

// File: rtl/rxd_fifo.sv
module rxd_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [DW-1:0]    push_data,
  input  logic             pop,
  output logic [DW-1:0]    head,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic [DW-1:0]    store [DEPTH];
  logic [PTR_W-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic             do_push, do_pop;

  assign full    = (lvl_q == FULL_LVL);
  assign empty   = (lvl_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = store[rd_q];
  assign level   = lvl_q;

  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_q;
    lvl_d = lvl_q;
    if (do_push) begin
      wr_d = (wr_q == LAST) ? '0 : wr_q + 1'b1;
    end
    if (do_pop) begin
      rd_d = (rd_q == LAST) ? '0 : rd_q + 1'b1;
    end
    if (do_push && !do_pop) begin
      lvl_d = lvl_q + 1'b1;
    end else if (do_pop && !do_push) begin
      lvl_d = lvl_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      lvl_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      lvl_q <= lvl_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_en;
    assign slot_en = do_push && (wr_q == PTR_W'(g));
    always_ff @(posedge clk) begin
      if (slot_en) begin
        store[g] <= push_data;
      end
    end
  end
endmodule

// File: rtl/rxd_ctrl.sv
module rxd_ctrl
  import rxd_pkg::*;
#(
  parameter int AW    = 16,
  parameter int LW    = 16,
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_addr_we,
  input  logic [AW-1:0]    cfg_addr_wdata,
  input  logic             cfg_len_we,
  input  logic [LW-1:0]    cfg_len_wdata,
  input  logic [LVL_W-1:0] q_level,
  input  logic             q_full,
  input  logic [DW-1:0]    q_head,
  input  logic             in_valid,
  input  logic [DW-1:0]    in_data,
  input  logic             mem_grant,
  output logic             in_ready,
  output logic             q_push,
  output logic             q_pop_drain,
  output logic             draining,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_data,
  output logic [AW-1:0]    ptr,
  output logic [LW-1:0]    remain
);
  rxd_state_e       state_q, state_d;
  logic [AW-1:0]    ptr_q, ptr_d;
  logic [LW-1:0]    rem_q, rem_d;
  logic [LVL_W-1:0] left_q, left_d;
  logic [LW-1:0]    lvl_ext;
  logic [LVL_W-1:0] take;
  logic             covered;
  logic             cfg_busy, bypass, idle, accept;

  assign idle     = (state_q == ST_IDLE);
  assign draining = (state_q == ST_DRAIN);
  assign cfg_busy = cfg_addr_we || cfg_len_we;
  assign bypass   = (rem_q != '0);

  assign in_ready    = idle && !cfg_busy && (bypass ? mem_grant : !q_full);
  assign accept      = in_valid && in_ready;
  assign q_push      = accept && !bypass;
  assign q_pop_drain = draining && mem_grant;

  assign mem_req  = draining || (idle && !cfg_busy && bypass && in_valid);
  assign mem_addr = ptr_q;
  assign mem_data = draining ? q_head : in_data;

  assign lvl_ext = LW'(q_level);
  assign covered = (cfg_len_wdata <= lvl_ext);
  assign take    = covered ? cfg_len_wdata[LVL_W-1:0] : q_level;

  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    rem_d   = rem_q;
    left_d  = left_q;
    if (cfg_addr_we) begin
      ptr_d   = cfg_addr_wdata;
      rem_d   = '0;
      left_d  = '0;
      state_d = ST_IDLE;
    end else if (idle && cfg_len_we) begin
      rem_d  = covered ? '0 : (cfg_len_wdata - lvl_ext);
      left_d = take;
      if (take != '0) begin
        state_d = ST_DRAIN;
      end
    end else if (draining && mem_grant) begin
      ptr_d  = ptr_q + 1'b1;
      left_d = left_q - 1'b1;
      if (left_q == LVL_W'(1)) begin
        state_d = ST_IDLE;
      end
    end else if (accept && bypass) begin
      ptr_d = ptr_q + 1'b1;
      rem_d = rem_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      rem_q   <= '0;
      left_q  <= '0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      rem_q   <= rem_d;
      left_q  <= left_d;
    end
  end

  assign ptr    = ptr_q;
  assign remain = rem_q;
endmodule

// File: rtl/rxd_status.sv
module rxd_status #(
  parameter int LW    = 16,
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic [LW-1:0]    remain,
  input  logic [LVL_W-1:0] q_level,
  input  logic             q_empty,
  input  logic [DW-1:0]    q_head,
  output logic [LW-1:0]    credit,
  output logic             done,
  output logic [DW-1:0]    pop_view
);
  localparam logic [LW-1:0] DEPTH_L = LW'(DEPTH);

  logic [LW-1:0] space;

  assign space    = DEPTH_L - LW'(q_level);
  assign done     = (remain == '0);
  assign credit   = done ? space : remain;
  assign pop_view = q_empty ? {DW{1'b1}} : q_head;
endmodule

// File: rtl/rx_dma_drain.sv
module rx_dma_drain #(
  parameter int AW    = 16,
  parameter int LW    = 16,
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_addr_we,
  input  logic [AW-1:0]    cfg_addr_wdata,
  input  logic             cfg_len_we,
  input  logic [LW-1:0]    cfg_len_wdata,
  output logic [AW-1:0]    rx_addr,
  output logic [LW-1:0]    rx_remain,
  output logic             rx_done,
  output logic [LW-1:0]    rx_credit,
  input  logic             in_valid,
  input  logic [DW-1:0]    in_data,
  output logic             in_ready,
  input  logic             sw_pop,
  output logic [DW-1:0]    sw_pop_data,
  output logic [LVL_W-1:0] fifo_level,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_data,
  input  logic             mem_grant
);
  logic          q_push, q_pop, q_pop_drain, q_full, q_empty, draining;
  logic [DW-1:0] q_head;
  logic          sw_pop_ok;

  assign sw_pop_ok = sw_pop && !q_empty && !draining && !cfg_len_we;
  assign q_pop     = q_pop_drain || sw_pop_ok;

  rxd_fifo #(.DW(DW), .DEPTH(DEPTH)) i_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (q_push),
    .push_data (in_data),
    .pop       (q_pop),
    .head      (q_head),
    .level     (fifo_level),
    .full      (q_full),
    .empty     (q_empty)
  );

  rxd_ctrl #(.AW(AW), .LW(LW), .DW(DW), .DEPTH(DEPTH)) i_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_addr_we    (cfg_addr_we),
    .cfg_addr_wdata (cfg_addr_wdata),
    .cfg_len_we     (cfg_len_we),
    .cfg_len_wdata  (cfg_len_wdata),
    .q_level        (fifo_level),
    .q_full         (q_full),
    .q_head         (q_head),
    .in_valid       (in_valid),
    .in_data        (in_data),
    .mem_grant      (mem_grant),
    .in_ready       (in_ready),
    .q_push         (q_push),
    .q_pop_drain    (q_pop_drain),
    .draining       (draining),
    .mem_req        (mem_req),
    .mem_addr       (mem_addr),
    .mem_data       (mem_data),
    .ptr            (rx_addr),
    .remain         (rx_remain)
  );

  rxd_status #(.LW(LW), .DW(DW), .DEPTH(DEPTH)) i_status (
    .remain   (rx_remain),
    .q_level  (fifo_level),
    .q_empty  (q_empty),
    .q_head   (q_head),
    .credit   (rx_credit),
    .done     (rx_done),
    .pop_view (sw_pop_data)
  );
endmodule

// File: rtl/rx_dma_drain_chk.sv
module rx_dma_drain_chk #(
  parameter int AW    = 16,
  parameter int LW    = 16,
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_addr_we,
  input logic [AW-1:0]    cfg_addr_wdata,
  input logic             cfg_len_we,
  input logic [LW-1:0]    cfg_len_wdata,
  input logic [AW-1:0]    rx_addr,
  input logic [LW-1:0]    rx_remain,
  input logic             rx_done,
  input logic             in_valid,
  input logic             in_ready,
  input logic [LVL_W-1:0] fifo_level,
  input logic             mem_req,
  input logic [AW-1:0]    mem_addr,
  input logic             mem_grant,
  input logic             draining
);
  assert_ptr_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_addr_we |=> (rx_addr == $past(cfg_addr_wdata)) && rx_done && (rx_remain == '0));

  assert_bypass_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (rx_remain != '0)) |=>
      (rx_remain == $past(rx_remain) - 1'b1) && (rx_addr == $past(rx_addr) + 1'b1)
      && (fifo_level == $past(fifo_level)));

  assert_shortfall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_len_we && !cfg_addr_we && !draining && (LW'(fifo_level) < cfg_len_wdata)) |=>
      (rx_remain == $past(cfg_len_wdata) - LW'($past(fifo_level))));

  assert_wait_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (draining && !mem_grant && !cfg_addr_we) |=> mem_req && $stable(mem_addr));

  assert_drain_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    draining |-> !in_ready);

  assert_full_block_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ((fifo_level == LVL_W'(DEPTH)) && (rx_remain == '0)) |-> !in_ready);
endmodule

bind rx_dma_drain rx_dma_drain_chk #(.AW(AW), .LW(LW), .DW(DW), .DEPTH(DEPTH)) i_chk (.*);

// File: tb/test_rx_dma_drain.sv
module test_rx_dma_drain;
  localparam int AW = 16, LW = 16, DW = 8, DEPTH = 8;
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam int NV = 19;
  // vector: op[1:0] arg[15:0] exp_remain[15:0] exp_addr[15:0] exp_level[3:0]
  // op: 0 push byte, 1 count write, 2 pointer write, 3 software pop
  localparam logic [53:0] VEC [NV] = '{
    {2'd2, 16'h0040, 16'd0, 16'h0040, 4'd0},
    {2'd0, 16'h0011, 16'd0, 16'h0040, 4'd1},
    {2'd0, 16'h0022, 16'd0, 16'h0040, 4'd2},
    {2'd0, 16'h0033, 16'd0, 16'h0040, 4'd3},
    {2'd1, 16'd2,    16'd0, 16'h0042, 4'd1},
    {2'd1, 16'd5,    16'd4, 16'h0043, 4'd0},
    {2'd0, 16'h0044, 16'd3, 16'h0044, 4'd0},
    {2'd0, 16'h0055, 16'd2, 16'h0045, 4'd0},
    {2'd2, 16'h0080, 16'd0, 16'h0080, 4'd0},
    {2'd0, 16'h0066, 16'd0, 16'h0080, 4'd1},
    {2'd3, 16'h0000, 16'd0, 16'h0080, 4'd0},
    {2'd1, 16'd0,    16'd0, 16'h0080, 4'd0},
    {2'd0, 16'h0077, 16'd0, 16'h0080, 4'd1},
    {2'd1, 16'd1,    16'd0, 16'h0081, 4'd0},
    {2'd1, 16'd3,    16'd3, 16'h0081, 4'd0},
    {2'd0, 16'h0088, 16'd2, 16'h0082, 4'd0},
    {2'd0, 16'h0099, 16'd1, 16'h0083, 4'd0},
    {2'd0, 16'h00AA, 16'd0, 16'h0084, 4'd0},
    {2'd0, 16'h00BB, 16'd0, 16'h0084, 4'd1}
  };

  logic clk, rst_n;
  logic cfg_addr_we, cfg_len_we, in_valid, in_ready, sw_pop, mem_req, mem_grant, rx_done;
  logic [AW-1:0] cfg_addr_wdata, rx_addr, mem_addr;
  logic [LW-1:0] cfg_len_wdata, rx_remain, rx_credit;
  logic [DW-1:0] in_data, sw_pop_data, mem_data;
  logic [LVL_W-1:0] fifo_level;

  logic [7:0]  mem [256];
  int          wr_count;
  logic [31:0] cyc;
  logic [1:0]  gnt_mode;
  int          checks, fails;
  bit          finished;

  rx_dma_drain #(.AW(AW), .LW(LW), .DW(DW), .DEPTH(DEPTH)) i_rx_dma_drain (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  assign mem_grant = (gnt_mode == 2'd0) ? 1'b1 :
                     (gnt_mode == 2'd1) ? (cyc[1:0] != 2'd0) : 1'b0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req && mem_grant) begin
      mem[mem_addr[7:0]] <= mem_data;
      wr_count <= wr_count + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wr_len(input logic [15:0] n);
    @(negedge clk);
    cfg_len_we = 1'b1;
    cfg_len_wdata = n;
    @(negedge clk);
    cfg_len_we = 1'b0;
  endtask

  task automatic wr_addr(input logic [15:0] a);
    @(negedge clk);
    cfg_addr_we = 1'b1;
    cfg_addr_wdata = a;
    @(negedge clk);
    cfg_addr_we = 1'b0;
  endtask

  task automatic pop;
    @(negedge clk);
    sw_pop = 1'b1;
    @(negedge clk);
    sw_pop = 1'b0;
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    int wc;
    checks = 0; fails = 0; finished = 1'b0;
    cyc = '0; wr_count = 0; gnt_mode = 2'd0;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    cfg_addr_we = 0; cfg_len_we = 0; in_valid = 0; sw_pop = 0;
    cfg_addr_wdata = '0; cfg_len_wdata = '0; in_data = '0;
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    check("R1 addr", 32'(rx_addr), 32'h0);
    check("R1 remain", 32'(rx_remain), 32'h0);
    check("R1 done", 32'(rx_done), 32'h1);
    check("R1 level", 32'(fifo_level), 32'h0);
    check("R1 credit", 32'(rx_credit), DEPTH);
    check("R1 ready", 32'(in_ready), 32'h1);
    check("R1 req", 32'(mem_req), 32'h0);

    // table walk: R2 R3 R4 R5 R6 R10 R11
    for (int v = 0; v < NV; v++) begin
      logic [53:0] e;
      e = VEC[v];
      case (e[53:52])
        2'd0: push(e[43:36]);
        2'd1: wr_len(e[51:36]);
        2'd2: wr_addr(e[51:36]);
        default: pop();
      endcase
      idle(12);
      checks++;
      if (rx_remain !== e[35:20] || rx_addr !== e[19:4] || fifo_level !== e[3:0]) begin
        fails++;
        $display("FAIL R2/R3/R5/R6 vector %0d actual=%h/%h/%h expected=%h/%h/%h", v,
                 rx_remain, rx_addr, fifo_level, e[35:20], e[19:4], e[3:0]);
      end
    end

    // R4 drained and bypassed bytes landed in order
    check("R4 m40", 32'(mem[8'h40]), 32'h11);
    check("R4 m41", 32'(mem[8'h41]), 32'h22);
    check("R4 m42", 32'(mem[8'h42]), 32'h33);
    check("R5 m43", 32'(mem[8'h43]), 32'h44);
    check("R5 m44", 32'(mem[8'h44]), 32'h55);
    check("R2 m80", 32'(mem[8'h80]), 32'h77);
    check("R5 m81", 32'(mem[8'h81]), 32'h88);
    check("R5 m83", 32'(mem[8'h83]), 32'hAA);
    check("R7 credit idle", 32'(rx_credit), 32'd7);

    // R10 zero count makes no memory write
    wc = wr_count;
    wr_len(16'd0);
    idle(4);
    check("R10 writes", 32'(wr_count), 32'(wc));
    check("R10 remain", 32'(rx_remain), 32'h0);

    // R12 full queue
    for (int i = 0; i < 7; i++) push(8'hC0 + 8'(i));
    idle(2);
    check("R12 ready", 32'(in_ready), 32'h0);
    check("R7 credit full", 32'(rx_credit), 32'h0);

    // R9 drain under a stalled grant, R4 order
    gnt_mode = 2'd1;
    wr_addr(16'h0010);
    wr_len(16'd8);
    idle(16);
    check("R9 addr", 32'(rx_addr), 32'h18);
    check("R2 remain", 32'(rx_remain), 32'h0);
    check("R9 level", 32'(fifo_level), 32'h0);
    check("R4 m10", 32'(mem[8'h10]), 32'hBB);
    check("R4 m11", 32'(mem[8'h11]), 32'hC0);
    check("R4 m17", 32'(mem[8'h17]), 32'hC6);

    // R6 cancel a stalled drain, R9 ignore a count write mid drain
    gnt_mode = 2'd0;
    for (int i = 0; i < 4; i++) push(8'hD0 + 8'(i));
    gnt_mode = 2'd2;
    wr_len(16'd6);
    idle(2);
    check("R9 ready low", 32'(in_ready), 32'h0);
    check("R9 req held", 32'(mem_req), 32'h1);
    check("R3 remain", 32'(rx_remain), 32'h2);
    check("R8 done low", 32'(rx_done), 32'h0);
    wr_len(16'd1);
    idle(1);
    check("R9 ignored", 32'(rx_remain), 32'h2);
    wc = wr_count;
    wr_addr(16'h00C0);
    gnt_mode = 2'd0;
    idle(4);
    check("R6 addr", 32'(rx_addr), 32'hC0);
    check("R6 remain", 32'(rx_remain), 32'h0);
    check("R6 level", 32'(fifo_level), 32'h4);
    check("R6 writes", 32'(wr_count), 32'(wc));
    check("R8 done", 32'(rx_done), 32'h1);

    // R11 software pop order and empty pop
    check("R11 head", 32'(sw_pop_data), 32'hD0);
    pop();
    check("R11 next", 32'(sw_pop_data), 32'hD1);
    pop(); pop(); pop();
    idle(1);
    check("R11 empty", 32'(sw_pop_data), 32'hFF);
    pop();
    idle(1);
    check("R11 empty level", 32'(fifo_level), 32'h0);

    // R7 credit follows outstanding length
    wr_len(16'd5);
    idle(2);
    check("R7 credit", 32'(rx_credit), 32'h5);
    check("R8 done", 32'(rx_done), 32'h0);

    summary();
  end
endmodule